// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between three asynchronous interrupt pins arriving from off-chip and an interrupt distributor that only understands two kinds of request: an active-high level or a rising edge. For each pin it synchronises the signal into the core clock domain. It samples the signal on one of two sampling-enable strobes and detects the programmed level or edge. It then drives one normalised request per line. Active-low levels are inverted, and falling edges are turned into a rising request.

Software controls the block through one 32-bit register. The register holds three byte-wide fields, one per line, and each field holds a trigger type, an enable, a strobe select and a pending flag. Writes carry per-byte strobes, so software can reprogram one line without a read-modify-write of the shared word.

In edge modes the line's request is a pending latch. The latch rises with the detected edge and stays high until software clears it. In level modes no latch is used, and the request tracks the qualified, sampled input.

Top module: `extint_conditioner`

## Requirements
- R1: After reset the register reads all zeros, so every line is disabled, in active-high level mode, not pending, and every request output is low.
- R2: Line 0's field occupies register bits 23:16, line 1's field bits 15:8 and line 2's field bits 7:0. Within a field, bit 0 is pending, bit 4 is strobe select, bit 5 is enable and bits 7:6 are the trigger type. Bits 3:1 of each field and bits 31:24 of the register read as zero.
- R3: A write changes only the fields whose byte strobe (cfg_be bit 2 for line 0, bit 1 for line 1, bit 0 for line 2) is set, and the other fields keep their values.
- R4: With type 00 (active-high level) and the line enabled, the request equals the synchronised, sampled pin.
- R5: With type 01 (active-low level) and the line enabled, the request is the inverse of the synchronised, sampled pin.
- R6: With type 10 (rising edge) and the line enabled, a low-to-high pin transition sets pending. The request stays high while pending is set, even after the pin returns low.
- R7: With type 11 (falling edge) and the line enabled, a high-to-low pin transition sets pending and raises the request, and a low-to-high transition does not set pending.
- R8: Writing 1 to a line's pending bit, with that line's byte strobe set, clears pending. Writing 0 to the pending bit leaves it unchanged.
- R9: When an edge is detected in the same cycle as a pending clear for that line, pending ends up set.
- R10: While a line's enable is 0 its request is low and edges do not set pending. After enable is set again, new edges raise requests.
- R11: The pin is sampled only on the strobe the line has selected (stb_fast when strobe select is 1, stb_slow when it is 0). Without that strobe the request does not follow the pin.
- R12: In level modes pending is never set and reads 0. Writing a level type clears any pending state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_be | input | 4 | Per-byte write strobes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| stb_slow | input | 1 | Sampling enable used when strobe select is 0 |
| stb_fast | input | 1 | Sampling enable used when strobe select is 1 |
| pin_in | input | 3 | Asynchronous external interrupt pins |
| req_out | output | 3 | Normalised requests to the distributor |

## Verification
Several behaviours are checked on every cycle by the assertions: pending sets after a detected edge, pending holds when no write touches its byte, a clear works when no edge collides with it, the sample register moves only on the selected strobe, unselected bytes stay unchanged, and pending stays low in level modes. The bench's scenarios are needed to show the rest. These are the end-to-end polarity conversion for all four trigger types on every line, the three-cycle path from pin to request, the priority of the edge when it coincides with a clear, and the effect of disabling a line and enabling it again.

// File: rtl/extint_conditioner.sv
module extint_conditioner #(
  parameter int NLINE = 3,
  parameter int FW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DW/8-1:0]  cfg_be,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             stb_slow,
  input  logic             stb_fast,
  input  logic [NLINE-1:0] pin_in,
  output logic [NLINE-1:0] req_out
);
  localparam int PAD = FW - 5;

  logic [NLINE-1:0] s1, s2;
  logic [NLINE-1:0] smp, pend, en, csel;
  logic [NLINE-1:0] wsel, clr, setev, tick, lvl, to_level;
  logic [1:0]       ttype [NLINE];
  logic [FW-1:0]    fld   [NLINE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < NLINE; i++) begin : g_line
    localparam int LSB = (NLINE - 1 - i) * FW;
    localparam int BY  = LSB / 8;

    assign wsel[i]     = cfg_we & cfg_be[BY];
    assign tick[i]     = csel[i] ? stb_fast : stb_slow;
    assign lvl[i]      = smp[i] ^ ttype[i][0];
    assign setev[i]    = en[i] & ttype[i][1] & tick[i] &
                         (ttype[i][0] ? (smp[i] & ~s2[i]) : (~smp[i] & s2[i]));
    assign clr[i]      = wsel[i] & cfg_wdata[LSB];
    assign to_level[i] = wsel[i] & ~cfg_wdata[LSB+7];
    assign req_out[i]  = en[i] & (ttype[i][1] ? pend[i] : lvl[i]);
    assign fld[i]      = {ttype[i], en[i], csel[i], {PAD{1'b0}}, pend[i]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ttype[i] <= 2'b00;
        en[i]    <= 1'b0;
        csel[i]  <= 1'b0;
        smp[i]   <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        if (wsel[i]) begin
          ttype[i] <= cfg_wdata[LSB+7:LSB+6];
          en[i]    <= cfg_wdata[LSB+5];
          csel[i]  <= cfg_wdata[LSB+4];
        end
        if (tick[i]) smp[i] <= s2[i];
        if (to_level[i])   pend[i] <= 1'b0;
        else if (setev[i]) pend[i] <= 1'b1;
        else if (clr[i])   pend[i] <= 1'b0;
      end
    end

    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      setev[i] && !wsel[i] |=> pend[i]);
    p_edge_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      setev[i] && clr[i] && !to_level[i] |=> pend[i]);
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !setev[i] |=> !pend[i]);
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pend[i] && !wsel[i] |=> pend[i]);
    p_sample_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick[i] |=> $stable(smp[i]));
    p_byte_isolate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel[i] |=> $stable(fld[i][FW-1:FW-4]));
    p_level_no_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ttype[i][1] |-> !pend[i]);
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NLINE; i++)
      cfg_rdata[(NLINE-1-i)*FW +: FW] = fld[i];
  end
endmodule

// File: tb/extint_conditioner_test.sv
module extint_conditioner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        stb_slow = 1'b0;
  logic        stb_fast = 1'b1;
  logic [2:0]  pin_in = '0;
  logic [2:0]  req_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  extint_conditioner uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stb_slow(stb_slow),
    .stb_fast(stb_fast), .pin_in(pin_in), .req_out(req_out)
  );

  // {type[1:0], pin before, pin after, expected request}
  localparam logic [4:0] VEC [8] = '{
    5'b00_01_1, 5'b00_10_0,   // R4
    5'b01_10_1, 5'b01_01_0,   // R5
    5'b10_01_1, 5'b10_10_0,   // R6
    5'b11_10_1, 5'b11_01_0    // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset rdata", cfg_rdata, 32'h0);
    chk("R1 reset req", {29'd0, req_out}, 32'h0);

    wr(4'hF, 32'hFFFF_FFFF);
    chk("R2 layout all ones", cfg_rdata, 32'h00F0_F0F0);
    wr(4'hF, 32'h0);
    wr(4'h2, 32'hFFFF_FFFF);
    chk("R3 only line1 written", cfg_rdata, 32'h0000_F000);
    wr(4'h5, 32'h0);
    chk("R3 line1 kept", cfg_rdata, 32'h0000_F000);
    wr(4'hF, 32'h0);

    for (int ln = 0; ln < 3; ln++) begin
      for (int v = 0; v < 8; v++) begin
        logic [3:0]  be;
        logic [31:0] f;
        be = 4'd1 << (2 - ln);
        f  = {24'd0, VEC[v][4:3], 2'b11, 4'b0001} << (8 * (2 - ln));
        pin_in[ln] = VEC[v][2];
        idle(6);
        wr(be, f);
        idle(6);
        pin_in[ln] = VEC[v][1];
        idle(6);
        chk($sformatf("R4/R5/R6/R7 line%0d vec%0d", ln, v),
            {31'd0, req_out[ln]}, {31'd0, VEC[v][0]});
      end
    end
    wr(4'hF, 32'h0);
    pin_in = '0;
    idle(6);

    wr(4'h2, 32'h0000_B000);
    pin_in[1] = 1'b1; idle(6);
    chk("R6 pending set", {31'd0, cfg_rdata[8]}, 32'd1);
    pin_in[1] = 1'b0; idle(6);
    chk("R6 req held after pin low", {31'd0, req_out[1]}, 32'd1);
    wr(4'h2, 32'h0000_B000);
    chk("R8 write 0 keeps pending", {31'd0, cfg_rdata[8]}, 32'd1);
    wr(4'h2, 32'h0000_B100);
    chk("R8 w1c clears pending", {31'd0, cfg_rdata[8]}, 32'd0);
    chk("R8 req low after clear", {31'd0, req_out[1]}, 32'd0);

    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_be = 4'h2; cfg_wdata = 32'h0000_B100;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
    chk("R9 edge wins over clear", {31'd0, cfg_rdata[8]}, 32'd1);
    wr(4'h2, 32'h0000_B100);
    pin_in[1] = 1'b0; idle(6);

    wr(4'h2, 32'h0000_9000);
    pin_in[1] = 1'b1; idle(6);
    chk("R10 disabled req low", {31'd0, req_out[1]}, 32'd0);
    chk("R10 disabled no pending", {31'd0, cfg_rdata[8]}, 32'd0);
    wr(4'h2, 32'h0000_B000);
    pin_in[1] = 1'b0; idle(6);
    pin_in[1] = 1'b1; idle(6);
    chk("R10 re-enabled edge raises req", {31'd0, req_out[1]}, 32'd1);
    wr(4'h2, 32'h0000_2000);
    chk("R12 level write clears pending", {31'd0, cfg_rdata[8]}, 32'd0);

    pin_in[1] = 1'b0; idle(8);
    chk("R11 no slow strobe, req holds", {31'd0, req_out[1]}, 32'd1);
    @(negedge clk); stb_slow = 1'b1;
    @(negedge clk); stb_slow = 1'b0;
    idle(2);
    chk("R11 slow strobe samples pin", {31'd0, req_out[1]}, 32'd0);

    wr(4'h2, 32'h0000_3000);
    pin_in[1] = 1'b1; idle(6);
    chk("R4 fast strobe level high", {31'd0, req_out[1]}, 32'd1);
    chk("R12 level mode pending reads 0", {31'd0, cfg_rdata[8]}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule